// File: doc/BRIEF.md
# Debug Pin Identification Stimulus Generator

This block sits between a bank of debug signals and the device pins that an external logic analyzer probes. When it is idle, the pins carry the normal bank data. When the identification walk is started, the block visits the pins in turn, one at a time. On the visited pin it drives a serial signature that carries that pin's index, and it holds every other pin low. An analyzer that sees a signature on one of its channels can decode which pin that channel is wired to, so no one has to enter the wiring by hand.

A second mode drives a pseudo-random test bank on every pin at once. All pins follow the same 7th-order maximal-length sequence, and each pin is offset from its neighbour by one step, so no two adjacent pins carry the same waveform. A single start level controls a run and a one-bit mode input chooses the kind of run. Dropping start ends any run at once and returns the pins to the bank data.

Top module: `pinmap_stim_gen`

## Requirements
- R1: While reset is high or start is low, `pins_out` equals `bank_data` in the same cycle and `done` is 0, whatever the value of `mode`.
- R2: During the identification walk, at most one bit of `pins_out` is 1. Every pin other than the active pin is 0, even when `bank_data` is all ones.
- R3: The active pin sends a 16-bit frame with the most significant bit first: the sync byte 0xA5, then the 8-bit pin index. Frame bit 15 appears in the first cycle after the clock edge that first samples start high with mode 0.
- R4: Each pin sends its frame REPEAT times in a row. The pins are visited in ascending order from 0 to NUM_PINS-1, so the walk lasts NUM_PINS*REPEAT*16 cycles.
- R5: After the last bit of the last pin, `done` goes to 1 on the next cycle. `done` stays at 1 and `pins_out` follows `bank_data` until start falls. `done` returns to 0 one cycle after start falls.
- R6: With mode 1 when the run starts, pin 0 emits the sequence s(k) = s(k-7) XOR s(k-6), with s(0)..s(6) equal to bits 0..6 of PRBS_SEED. s(0) appears in the first cycle of the run, and every later run restarts at s(0).
- R7: In the test bank, pin i in run cycle n drives s(n+i). Each pin therefore lags its upper neighbour by one cycle.
- R8: If start goes low in any mode, the pins return to `bank_data` on the next cycle. The next walk starts again at pin 0, frame bit 15.
- R9: The mode is captured only when a run begins. Changing `mode` during a walk or a test-bank run does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | High to run; low aborts and returns to idle |
| mode | input | 1 | 0 = identification walk, 1 = pseudo-random test bank; sampled at run start |
| bank_data | input | NUM_PINS | Normal debug bank data shown when not running |
| pins_out | output | NUM_PINS | Debug pin drive |
| done | output | 1 | Identification walk finished |

## Verification
The assertions check on every cycle that the walk never drives more than one pin, that the walk cursor steps up by exactly one pin at each pin boundary and returns home on a clear, and that a dropped start always lands in idle. They also check that the test-bank window shifts by one place per cycle, so that each pin repeats its upper neighbour one cycle later. Only the bench's scenarios can show the actual signature bits: the sync byte, the index byte, the repeat count and the exact cycle in which `done` rises. The same holds for the sequence values taken from the seed and for the cycle-exact behaviour when a run is aborted and restarted.

// File: rtl/pinmap_pkg.sv
package pinmap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_PRBS = 2'd2,
        ST_DONE = 2'd3
    } pm_state_e;

    typedef enum logic {
        MODE_WALK = 1'b0,
        MODE_PRBS = 1'b1
    } pm_mode_e;

    localparam logic [7:0] SYNC_BYTE   = 8'hA5;
    localparam int         FRAME_BITS  = 16;
    localparam int         PRBS_ORDER  = 7;
    localparam int         PRBS_TAP_LO = 6;

    // Position of the walk within one pin's frame train
    typedef struct packed {
        logic [7:0] pin;
        logic [3:0] bit_pos;
    } pm_cursor_t;

    // Serial frame bit; pos 0 is the first bit on the wire (frame MSB)
    function automatic logic frame_bit(input logic [7:0] idx, input logic [3:0] pos);
        logic [15:0] frame;
        frame = {SYNC_BYTE, idx};
        return frame[4'd15 - pos];
    endfunction

endpackage

// File: rtl/pinmap_walk_seq.sv
module pinmap_walk_seq
    import pinmap_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int REPEAT   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       step,
    output pm_cursor_t cur,
    output logic       last
);
    localparam int REP_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;
    localparam logic [REP_W-1:0] REP_MAX = REP_W'(REPEAT - 1);
    localparam logic [7:0]       PIN_MAX = 8'(NUM_PINS - 1);

    pm_cursor_t       cur_q;
    logic [REP_W-1:0] rep_q;
    logic             frame_end;
    logic             pin_end;

    assign frame_end = (cur_q.bit_pos == 4'd15);
    assign pin_end   = frame_end && (rep_q == REP_MAX);
    assign last      = pin_end && (cur_q.pin == PIN_MAX);
    assign cur       = cur_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur_q <= '0;
            rep_q <= '0;
        end else if (step) begin
            if (!frame_end) begin
                cur_q.bit_pos <= cur_q.bit_pos + 4'd1;
            end else begin
                cur_q.bit_pos <= 4'd0;
                if (rep_q != REP_MAX) begin
                    rep_q <= rep_q + REP_W'(1);
                end else begin
                    rep_q     <= '0;
                    cur_q.pin <= last ? 8'd0 : cur_q.pin + 8'd1;
                end
            end
        end
    end

    // R8: a clear always brings the cursor home
    p_clear_home_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cur_q.pin == 8'd0 && cur_q.bit_pos == 4'd0));

    // R4: inside a frame train the pin does not change
    p_pin_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !pin_end) |=> (cur_q.pin == $past(cur_q.pin)));

    // R4: at a pin boundary the walk moves to the next pin up
    p_pin_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && pin_end && !last) |=> (cur_q.pin == $past(cur_q.pin) + 8'd1));

    // R4: the cursor never leaves the pin range
    p_pin_range_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_q.pin <= PIN_MAX));

endmodule

// File: rtl/pinmap_sig_frame.sv
module pinmap_sig_frame
    import pinmap_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  pm_cursor_t          cur,
    input  logic                en,
    output logic [NUM_PINS-1:0] drive
);
    logic serial_bit;

    assign serial_bit = frame_bit(cur.pin, cur.bit_pos);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign drive[p] = en && (cur.pin == 8'(p)) && serial_bit;
    end

endmodule

// File: rtl/pinmap_prbs_bank.sv
module pinmap_prbs_bank
    import pinmap_pkg::*;
#(
    parameter int         NUM_PINS = 8,
    parameter logic [6:0] SEED     = 7'h5B
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                shift,
    output logic [NUM_PINS-1:0] bits
);
    localparam int WIN = (NUM_PINS < PRBS_ORDER) ? PRBS_ORDER : NUM_PINS;

    // Window bit j holds s(n+j) for the current run cycle n
    function automatic logic [WIN-1:0] seed_window();
        logic [WIN-1:0] w;
        w = '0;
        for (int j = 0; j < WIN; j++) begin
            if (j < PRBS_ORDER) w[j] = SEED[j];
            else                w[j] = w[j-PRBS_ORDER] ^ w[j-PRBS_TAP_LO];
        end
        return w;
    endfunction

    localparam logic [WIN-1:0] INIT_WIN = seed_window();

    logic [WIN-1:0] win_q;
    logic [WIN-1:0] win_nxt;
    logic           new_bit;

    assign new_bit = win_q[WIN-PRBS_ORDER] ^ win_q[WIN-PRBS_TAP_LO];
    assign win_nxt = {new_bit, win_q[WIN-1:1]};
    assign bits    = win_q[NUM_PINS-1:0];

    always_ff @(posedge clk) begin
        if (rst || load) begin
            win_q <= INIT_WIN;
        end else if (shift) begin
            win_q <= win_nxt;
        end
    end

    // R7: each window slot takes its upper neighbour's previous value
    p_window_shift_r7: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (win_q[WIN-2:0] == $past(win_q[WIN-1:1])));

    // R6: a maximal-length sequence window never collapses to zero
    p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        (win_q != '0));

endmodule

// File: rtl/pinmap_stim_gen.sv
module pinmap_stim_gen
    import pinmap_pkg::*;
#(
    parameter int         NUM_PINS  = 8,
    parameter int         REPEAT    = 2,
    parameter logic [6:0] PRBS_SEED = 7'h5B
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                mode,
    input  logic [NUM_PINS-1:0] bank_data,
    output logic [NUM_PINS-1:0] pins_out,
    output logic                done
);
    pm_state_e           state_q;
    pm_state_e           state_nxt;
    pm_cursor_t          cursor;
    logic                walk_last;
    logic                walk_clear;
    logic                walk_step;
    logic                prbs_load;
    logic                prbs_shift;
    logic [NUM_PINS-1:0] walk_drive;
    logic [NUM_PINS-1:0] prbs_bits;

    assign walk_step  = (state_q == ST_WALK) && start;
    assign walk_clear = !walk_step;
    assign prbs_load  = (state_q != ST_PRBS);
    assign prbs_shift = (state_q == ST_PRBS);

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nxt = (pm_mode_e'(mode) == MODE_PRBS) ? ST_PRBS : ST_WALK;
            ST_WALK: begin
                if (!start)         state_nxt = ST_IDLE;
                else if (walk_last) state_nxt = ST_DONE;
            end
            ST_PRBS: if (!start) state_nxt = ST_IDLE;
            ST_DONE: if (!start) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nxt;
    end

    pinmap_walk_seq #(
        .NUM_PINS (NUM_PINS),
        .REPEAT   (REPEAT)
    ) u_walk (
        .clk   (clk),
        .rst   (rst),
        .clear (walk_clear),
        .step  (walk_step),
        .cur   (cursor),
        .last  (walk_last)
    );

    pinmap_sig_frame #(
        .NUM_PINS (NUM_PINS)
    ) u_frame (
        .cur   (cursor),
        .en    (state_q == ST_WALK),
        .drive (walk_drive)
    );

    pinmap_prbs_bank #(
        .NUM_PINS (NUM_PINS),
        .SEED     (PRBS_SEED)
    ) u_prbs (
        .clk   (clk),
        .rst   (rst),
        .load  (prbs_load),
        .shift (prbs_shift),
        .bits  (prbs_bits)
    );

    always_comb begin
        unique case (state_q)
            ST_WALK: pins_out = walk_drive;
            ST_PRBS: pins_out = prbs_bits;
            default: pins_out = bank_data;
        endcase
    end

    assign done = (state_q == ST_DONE);

    // R2: the walk drives at most one pin
    p_one_pin_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WALK) |-> $onehot0(pins_out));

    // R5: finishing the last pin raises done on the next cycle
    p_done_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (walk_step && walk_last) |=> done);

    // R8: a low start always lands in idle with done clear
    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        !start |=> (state_q == ST_IDLE && !done));

    // R9: a running walk stays a walk regardless of mode
    p_walk_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (walk_step && !walk_last) |=> (state_q == ST_WALK));

    // R7: in the test bank each pin repeats its upper neighbour one cycle later
    p_phase_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRBS && $past(state_q) == ST_PRBS)
            |-> (pins_out[NUM_PINS-2:0] == $past(pins_out[NUM_PINS-1:1])));

endmodule

// File: tb/pinmap_stim_gen_tb.sv
module pinmap_stim_gen_tb;
    localparam int         NP       = 8;
    localparam int         REP      = 2;
    localparam logic [6:0] SEED     = 7'h5B;
    localparam int         FRAME    = 16;
    localparam int         WALK_LEN = NP * REP * FRAME;
    localparam int         PRBS_RUN = 150;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [NP-1:0] bank = '0;
    logic [NP-1:0] pins_out;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int s [0:PRBS_RUN+NP+8];

    always #10 clk = ~clk;

    pinmap_stim_gen #(
        .NUM_PINS  (NP),
        .REPEAT    (REP),
        .PRBS_SEED (SEED)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .bank_data (bank),
        .pins_out  (pins_out),
        .done      (done)
    );

    typedef struct packed {
        logic          mode;
        logic [NP-1:0] bank;
        logic [NP-1:0] exp;
    } vec_t;

    localparam vec_t IDLE_VEC [6] = '{
        '{1'b0, 8'h00, 8'h00},
        '{1'b1, 8'hFF, 8'hFF},
        '{1'b0, 8'hA5, 8'hA5},
        '{1'b1, 8'h5A, 8'h5A},
        '{1'b0, 8'h81, 8'h81},
        '{1'b1, 8'h3C, 8'h3C}
    };

    task automatic check_vec(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NP-1:0] walk_exp(input int c);
        int          pin;
        int          pos;
        logic [15:0] f;
        pin = c / (REP * FRAME);
        pos = c % FRAME;
        f   = {8'hA5, 8'(pin)};
        return f[15-pos] ? ({{(NP-1){1'b0}}, 1'b1} << pin) : '0;
    endfunction

    function automatic logic [NP-1:0] prbs_exp(input int c);
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = s[c+i][0];
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j <= PRBS_RUN + NP + 8; j++) begin
            if (j < 7) s[j] = int'(SEED[j]);
            else       s[j] = s[j-7] ^ s[j-6];
        end

        // R1: reset state passes bank data through
        @(negedge clk);
        bank = 8'h3C;
        @(negedge clk);
        check_vec("R1 reset pins", pins_out, 8'h3C);
        check_bit("R1 reset done", done, 1'b0);
        rst = 1'b0;

        // R1: idle pass-through table, any mode
        for (int k = 0; k < 6; k++) begin
            mode = IDLE_VEC[k].mode;
            bank = IDLE_VEC[k].bank;
            @(negedge clk);
            check_vec("R1 idle pins", pins_out, IDLE_VEC[k].exp);
            check_bit("R1 idle done", done, 1'b0);
        end

        // R2 R3 R4: full walk with all-ones bank; R9 mode flip mid-walk
        mode  = 1'b0;
        bank  = 8'hFF;
        start = 1'b1;
        for (int c = 0; c < WALK_LEN; c++) begin
            @(negedge clk);
            check_vec("R2 R3 R4 walk", pins_out, walk_exp(c));
            if (c == 21) check_vec("R9 mode ignored in walk", pins_out, walk_exp(c));
            if (c == WALK_LEN - 1) check_bit("R5 done low on last bit", done, 1'b0);
            if (c == 20) mode = 1'b1;
        end

        // R5: done and bank pass-through after the walk
        @(negedge clk);
        check_bit("R5 done high", done, 1'b1);
        check_vec("R5 pins follow bank", pins_out, 8'hFF);
        bank = 8'h5A;
        #1;
        check_vec("R5 pins follow new bank", pins_out, 8'h5A);
        repeat (3) @(negedge clk);
        check_bit("R5 done held", done, 1'b1);
        start = 1'b0;
        @(negedge clk);
        check_bit("R5 done cleared", done, 1'b0);
        check_vec("R5 pins after release", pins_out, 8'h5A);

        // R8: abort a walk on pin 1, then restart from pin 0
        mode  = 1'b0;
        bank  = 8'hC3;
        start = 1'b1;
        repeat (40) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check_vec("R8 abort pins", pins_out, 8'hC3);
        check_bit("R8 abort done", done, 1'b0);
        start = 1'b1;
        for (int c = 0; c < REP * FRAME + 4; c++) begin
            @(negedge clk);
            check_vec("R8 restart walk", pins_out, walk_exp(c));
        end
        start = 1'b0;
        @(negedge clk);

        // R6 R7: test bank; R9 mode flip mid-run
        mode  = 1'b1;
        start = 1'b1;
        for (int c = 0; c < PRBS_RUN; c++) begin
            @(negedge clk);
            check_bit("R6 pin0 sequence", pins_out[0], s[c][0]);
            check_vec("R7 pin phases", pins_out, prbs_exp(c));
            if (c == 11) check_vec("R9 mode ignored in test bank", pins_out, prbs_exp(c));
            if (c == 10) mode = 1'b0;
        end

        // R8: abort the test bank, then R6 restart from s(0)
        start = 1'b0;
        bank  = 8'h0F;
        @(negedge clk);
        check_vec("R8 abort test bank", pins_out, 8'h0F);
        check_bit("R8 abort test bank done", done, 1'b0);
        mode  = 1'b1;
        start = 1'b1;
        @(negedge clk);
        check_vec("R6 reload at restart", pins_out, prbs_exp(0));
        start = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule